// File: doc/BRIEF.md
# Max-Tracking ReLU Requantizer

This block turns one layer's signed 32-bit accumulator results into unsigned 8-bit activations for the next layer. The conversion runs in two passes. In the first pass the results stream in as groups of `N` values. A pipelined tree of signed comparators reduces each group to its local maximum. A per-layer maximum register takes that local value only when it is larger. Negative values never win, because the register starts the layer at zero.

When the layer closes, a logarithmic leading-one search runs on the stored maximum. It produces a bit position, which is clamped into the range 6..30, and the block latches that position minus 6 as a right-shift amount. In the second pass the same results come back as groups of `M` values. Each lane is clipped at zero, shifted right by the latched amount and cut to 8 bits. The layer maximum therefore lands in the low seven bits, and the top output bit stays clear. The scale comes from a shift, so no divider is needed, and the stream never stalls.

Top module: `relu_requant`

## Requirements
- R1: While reset is held and right after it, `q_valid`, `shift_valid`, `shift_amt` and `q_data` are all zero.
- R2: During requantization, any lane whose input is negative (bit 31 of its 32-bit slice set) outputs 0, whatever the shift amount.
- R3: The layer maximum is the largest non-negative value among all lanes of every group accepted with `acc_valid` since the last `layer_start`. It is 0 if no such value exists.
- R4: `layer_start` clears the layer maximum to 0 and drops `shift_valid` on the next edge. The result of a previous layer therefore has no effect on the next one.
- R5: The shift amount is `clamp(pos, 6, 30) - 6`, where `pos` is the index (bit 0 = LSB) of the highest set bit of the layer maximum. A maximum below 128 gives 0, and the largest possible shift is 24.
- R6: `shift_amt` is updated and `shift_valid` rises on the edge that comes log2(N)+2 edges after the edge that samples `layer_end`. `layer_end` may be asserted together with the last group.
- R7: `q_valid` follows `rq_valid` by exactly one edge. Output lane j sits at `q_data[8j+7:8j]` and comes from input lane `rq_data[32j+31:32j]`.
- R8: A non-negative lane value x gives `min(x >> shift_amt, 127)`, so output bit 7 of every lane is 0.
- R9: `acc_data` is ignored in any cycle where `acc_valid` is low, even when it carries values above the true maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| layer_start | input | 1 | Pulse that opens a new layer and clears its maximum |
| acc_valid | input | 1 | Qualifies `acc_data` in the search pass |
| acc_data | input | N*32 | N signed accumulator results, lane j at bits 32j+31:32j |
| layer_end | input | 1 | Pulse that marks the last search group of the layer |
| rq_valid | input | 1 | Qualifies `rq_data` in the requantize pass |
| rq_data | input | M*32 | M signed results to requantize |
| shift_valid | output | 1 | Shift amount for the current layer is ready |
| shift_amt | output | 5 | Latched right-shift amount, 0..24 |
| q_valid | output | 1 | Qualifies `q_data` |
| q_data | output | M*8 | M requantized activations |

## Verification
The bench sweeps the bit position of the layer maximum across every value from 0 to 30, and it adds one layer made only of negative inputs. This separates the clamp at the low end, every step of the leading-one search, and the top shift of 24. The maximum is placed in a different lane and a different group each time, and negative values are mixed into the groups. This shows whether every comparator in the tree and the register's zero floor behave correctly. On alternate layers an invalid cycle carrying a huge value is inserted, and a large layer is followed by a small one, so that leaks from unqualified data or from the previous layer become visible. The requantize groups mix the maximum itself, zero, negative values, random in-range values and oversized values, which tells truncation apart from clipping and saturation.

// File: rtl/relu_requant.sv
`timescale 1ns/1ps
module relu_requant #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int DW = 32,
  parameter int OW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            layer_start,
  input  logic            acc_valid,
  input  logic [N*DW-1:0] acc_data,
  input  logic            layer_end,
  input  logic            rq_valid,
  input  logic [M*DW-1:0] rq_data,
  output logic            shift_valid,
  output logic [4:0]      shift_amt,
  output logic            q_valid,
  output logic [M*OW-1:0] q_data
);
  localparam int LV    = $clog2(N);
  localparam int PW    = 5;
  localparam int LOPOS = OW - 2;
  localparam logic [PW-1:0] LOPOS_L = PW'(LOPOS);
  localparam logic [PW-1:0] MAXSH_L = PW'(DW - 2 - LOPOS);
  localparam logic [DW-1:0] QMAX    = DW'((1 << (OW - 1)) - 1);

  // comparator tree, one register per level
  for (genvar l = 0; l <= LV; l++) begin : lvl
    localparam int W = N >> l;
    logic signed [DW-1:0] t [W];
    logic v;
    if (l == 0) begin : g_in
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) v <= 1'b0;
        else        v <= acc_valid;
      always_ff @(posedge clk)
        if (acc_valid)
          for (int i = 0; i < W; i++) t[i] <= acc_data[i*DW +: DW];
    end else begin : g_red
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) v <= 1'b0;
        else        v <= lvl[l-1].v;
      always_ff @(posedge clk)
        for (int i = 0; i < W; i++)
          t[i] <= (lvl[l-1].t[2*i] > lvl[l-1].t[2*i+1]) ? lvl[l-1].t[2*i] : lvl[l-1].t[2*i+1];
    end
  end

  logic signed [DW-1:0] top_t;
  logic                 top_v;
  assign top_t = lvl[LV].t[0];
  assign top_v = lvl[LV].v;

  logic signed [DW-1:0] gmax;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      gmax <= '0;
    else if (layer_start)            gmax <= '0;
    else if (top_v && top_t > gmax)  gmax <= top_t;

  // R3
  always @(posedge clk)
    gmax_nonneg_chk: assert property (disable iff (!rst_n) !gmax[DW-1]);
  // R3
  always @(posedge clk)
    gmax_mono_chk: assert property (disable iff (!rst_n)
      !layer_start |=> gmax >= $past(gmax));

  logic [LV+1:0] ev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ev <= '0;
    else        ev <= {ev[LV:0], layer_end};

  function automatic logic [PW-1:0] lead_one(input logic [DW-1:0] x);
    logic [DW-1:0] v;
    logic [PW-1:0] p;
    v = x;
    p = '0;
    for (int s = DW / 2; s > 0; s = s / 2)
      if ((v >> s) != '0) begin
        p = p + PW'(s);
        v = v >> s;
      end
    return p;
  endfunction

  logic [PW-1:0] pos_raw, pos_c;
  assign pos_raw = lead_one(gmax);
  assign pos_c   = (pos_raw < LOPOS_L) ? LOPOS_L : pos_raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shift_valid <= 1'b0;
      shift_amt   <= '0;
    end else if (layer_start) begin
      shift_valid <= 1'b0;
    end else if (ev[LV+1]) begin
      shift_valid <= 1'b1;
      shift_amt   <= pos_c - LOPOS_L;
    end

  // R5
  always @(posedge clk)
    shift_range_chk: assert property (disable iff (!rst_n) shift_amt <= MAXSH_L);
  // R4
  always @(posedge clk)
    start_clear_chk: assert property (disable iff (!rst_n)
      layer_start |=> (gmax == '0) && !shift_valid);

  // requantize pass
  logic [M*OW-1:0] q_next;
  for (genvar j = 0; j < M; j++) begin : lane
    logic [DW-1:0] x, sh;
    assign x  = rq_data[j*DW +: DW];
    assign sh = x >> shift_amt;
    assign q_next[j*OW +: OW] = x[DW-1] ? '0 : (sh > QMAX) ? QMAX[OW-1:0] : sh[OW-1:0];

    // R2
    always @(posedge clk)
      neg_zero_chk: assert property (disable iff (!rst_n)
        (rq_valid && rq_data[j*DW+DW-1]) |=> (q_data[j*OW +: OW] == '0));
    // R8
    always @(posedge clk)
      msb_clear_chk: assert property (disable iff (!rst_n)
        q_valid |-> !q_data[j*OW+OW-1]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= rq_valid;
      if (rq_valid) q_data <= q_next;
    end

  // R7
  always @(posedge clk)
    q_follow_chk: assert property (disable iff (!rst_n) rq_valid |=> q_valid);
  // R7
  always @(posedge clk)
    q_idle_chk: assert property (disable iff (!rst_n) !rq_valid |=> !q_valid);
endmodule

// File: tb/test_relu_requant.sv
`timescale 1ns/1ps
module test_relu_requant;
  localparam int N  = 4;
  localparam int M  = 4;
  localparam int LV = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic layer_start = 1'b0, acc_valid = 1'b0, layer_end = 1'b0, rq_valid = 1'b0;
  logic [N*32-1:0] acc_data = '0;
  logic [M*32-1:0] rq_data = '0;
  logic shift_valid, q_valid;
  logic [4:0] shift_amt;
  logic [M*8-1:0] q_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  relu_requant #(.N(N), .M(M)) i_relu_requant (
    .clk(clk), .rst_n(rst_n), .layer_start(layer_start), .acc_valid(acc_valid),
    .acc_data(acc_data), .layer_end(layer_end), .rq_valid(rq_valid), .rq_data(rq_data),
    .shift_valid(shift_valid), .shift_amt(shift_amt), .q_valid(q_valid), .q_data(q_data));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_shift(input int g);
    int p = 0;
    for (int k = 30; k >= 0; k--) if (g[k]) begin p = k; break; end
    return (p < 6) ? 0 : p - 6;
  endfunction

  function automatic int exp_q(input int x, input int sh);
    int r;
    if (x < 0) return 0;
    r = x >>> sh;
    return (r > 127) ? 127 : r;
  endfunction

  // p < 0: every value negative
  task automatic run_layer(input int p, input int ngrp, input bit poison);
    int gexp = 0, sh, v;
    int mask;
    mask = (p <= 0) ? 0 : ((1 << p) - 1);
    layer_start = 1'b1; step(); layer_start = 1'b0;
    chk("R4 shift_valid cleared", shift_valid, 0);
    for (int g = 0; g < ngrp; g++) begin
      if (poison && g == 1) begin
        acc_valid = 1'b0;
        for (int j = 0; j < N; j++) acc_data[j*32 +: 32] = 32'h7FFF_FFFF;
        step();
      end
      for (int j = 0; j < N; j++) begin
        if (p < 0) v = -int'($urandom_range(1000000)) - 1;
        else if (g == (p % ngrp) && j == (p % N)) v = (1 << p) | (int'($urandom) & mask);
        else if ($urandom_range(2) == 0) v = -int'($urandom & 32'h3FFF_FFFF) - 1;
        else v = int'($urandom) & mask;
        acc_data[j*32 +: 32] = v;
        if (v > gexp) gexp = v;
      end
      acc_valid = 1'b1;
      layer_end = (g == ngrp - 1);
      step();
    end
    acc_valid = 1'b0; layer_end = 1'b0; acc_data = '0;
    for (int k = 0; k < LV + 1; k++) step();
    chk("R6 shift_valid not early", shift_valid, 0);
    step();
    chk("R6 shift_valid on time", shift_valid, 1);
    sh = exp_shift(gexp);
    chk((p < 0) ? "R3 all-negative layer" : "R5 shift amount", shift_amt, sh);
    // requantize pass
    for (int g = 0; g < 3; g++) begin
      int xs [M];
      for (int j = 0; j < M; j++) begin
        case ((g * M + j) % 6)
          0: xs[j] = gexp;
          1: xs[j] = 0;
          2: xs[j] = -int'($urandom_range(500000)) - 1;
          3: xs[j] = (gexp > 0) ? int'($urandom_range(gexp)) : 0;
          4: xs[j] = 32'h7FFF_FFFF;
          default: xs[j] = int'($urandom) & mask;
        endcase
        rq_data[j*32 +: 32] = xs[j];
      end
      rq_valid = 1'b1; step();
      chk("R7 q_valid after rq_valid", q_valid, 1);
      for (int j = 0; j < M; j++)
        chk(xs[j] < 0 ? "R2 negative lane" : "R8 lane value",
            int'(q_data[j*8 +: 8]), exp_q(xs[j], sh));
      rq_valid = 1'b0; step();
      chk("R7 q_valid idle", q_valid, 0);
    end
  endtask

  initial begin
    step(); step();
    chk("R1 q_valid reset", q_valid, 0);
    chk("R1 shift_valid reset", shift_valid, 0);
    chk("R1 shift_amt reset", shift_amt, 0);
    chk("R1 q_data reset", int'(q_data), 0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", shift_valid, 0);
    for (int p = 0; p <= 30; p++) run_layer(p, 3, p[0]); // R9 on odd layers
    run_layer(30, 1, 1'b0);
    run_layer(-1, 2, 1'b1);   // R4: after a large layer, an all-negative one
    run_layer(3, 2, 1'b1);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule